// File: doc/BRIEF.md
# Super I/O Configuration Window

This block is a slave register block on a narrow synchronous I/O bus. It presents two byte-wide ports. The index port, at address 0, selects a register. The data port, at address 1, reads or writes the selected register. Behind this window sits a global configuration space that stays closed until a key byte is written twice in a row to the index port. While the space is closed, the data port reaches nothing. A separate lock byte closes the space again.

Inside the configuration space there are:
- fixed identification registers for the chip and for the manufacturer;
- a logical-device select register;
- for each logical device, a banked 16-bit I/O base address, written and read one byte at a time.

The base address of the hardware-monitor device is always driven out, so that downstream address decode can place that function without the configuration space being open.

Top module: `sio_cfg_window`

## Requirements
- R1: Address 0 is the index port and address 1 is the data port. Read data is registered: it is valid in the cycle after the read strobe and holds its value while no read strobe is present.
- R2: The space opens only after two back-to-back index-port writes of 0x87. Any other index-port write that arrives while the space is closed returns the key sequence to its start.
- R3: An index-port write of 0xAA while the space is open closes it.
- R4: While the space is closed, a read at either address returns 0xFF. Data-port writes are ignored, and the index register is not changed.
- R5: After reset the space is closed, the device select is 0x00, the monitor base is 0x0290, and the read data is 0x00.
- R6: Indices 0x20 and 0x21 return the chip ID 0x0541, high byte first. Indices 0x23 and 0x24 return the manufacturer ID 0x1934, high byte first. Writes to these four indices have no effect.
- R7: Index 0x07 is the 8-bit logical-device select, which can be both read and written.
- R8: Index 0x60 holds the high byte and index 0x61 the low byte of the 16-bit base of the selected device. Each of the 8 devices (select values 0 to 7) keeps its own value. Any select value of 8 or above reads 0x00 and ignores writes.
- R9: The monitor base output is the base of device 4. It changes only on a data-port write, and it shows the new value right after the clock edge that samples that write.
- R10: Every index not listed above reads 0x00.
- R11: While the space is open, a read of the index port returns the current index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | 0 = index port, 1 = data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| mon_base | output | 16 | I/O base of the hardware-monitor device |

## Verification
A key sequencer stuck in its armed or open state shows up at the very next data-port read: that read returns register contents where 0xFF is expected, or 0xFF where register contents are expected. A wrong bank entry or a wrong device select stays hidden until its index is read back, or, for device 4, until the monitor base output is sampled one edge after the write. For this reason the bench sweeps every stray byte between the two key writes. It also sweeps every index with a known bank pattern loaded, so that any wrongly decoded register is caught within one read.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [1:0] {
      KS_SHUT  = 2'd0,
      KS_ARMED = 2'd1,
      KS_OPEN  = 2'd2
   } key_state_e;

   localparam byte_t IX_LDSEL   = 8'h07;
   localparam byte_t IX_CHIP_HI = 8'h20;
   localparam byte_t IX_CHIP_LO = 8'h21;
   localparam byte_t IX_MFG_HI  = 8'h23;
   localparam byte_t IX_MFG_LO  = 8'h24;
   localparam byte_t IX_BASE_HI = 8'h60;
   localparam byte_t IX_BASE_LO = 8'h61;
endpackage

// File: rtl/sio_key_gate.sv
module sio_key_gate
   import sio_cfg_pkg::*;
#(
   parameter byte_t KEY_BYTE  = 8'h87,
   parameter byte_t LOCK_BYTE = 8'hAA
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  idx_wr,
   input  byte_t wdata,
   output logic  open
);
   if (KEY_BYTE == LOCK_BYTE) begin : g_bad_bytes
      $error("sio_key_gate: key and lock bytes must differ");
   end

   key_state_e state_q, state_d;
   logic key_wr;
   logic lock_wr;

   assign key_wr  = idx_wr && (wdata == KEY_BYTE);
   assign lock_wr = idx_wr && (wdata == LOCK_BYTE);

   always_comb begin
      state_d = state_q;
      case (state_q)
         KS_SHUT:  if (key_wr) state_d = KS_ARMED;
         KS_ARMED: if (idx_wr) state_d = key_wr ? KS_OPEN : KS_SHUT;
         KS_OPEN:  if (lock_wr) state_d = KS_SHUT;
         default:  state_d = KS_SHUT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= KS_SHUT;
      else        state_q <= state_d;
   end

   assign open = (state_q == KS_OPEN);

   // R2: the space opens only straight after an armed state that saw a second key
   a_r2_open_needs_two_keys: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open) |-> $past(state_q == KS_ARMED && key_wr));
   // R2: a foreign byte between the two keys disarms the sequence
   a_r2_foreign_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == KS_ARMED && idx_wr && !key_wr) |=> (state_q == KS_SHUT));
   // R3: the lock byte closes an open space
   a_r3_lock_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (open && lock_wr) |=> !open);
endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
   import sio_cfg_pkg::*;
#(
   parameter int unsigned NUM_LDEV     = 8,
   parameter int unsigned MON_LDEV     = 4,
   parameter logic [15:0] MON_BASE_RST = 16'h0290,
   parameter logic [15:0] DEV_BASE_RST = 16'h0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  byte_t       sel,
   input  logic        wr_hi,
   input  logic        wr_lo,
   input  byte_t       wdata,
   output byte_t       rd_hi,
   output byte_t       rd_lo,
   output logic [15:0] mon_base
);
   localparam int unsigned SEL_SPAN = 1 << BYTE_W;

   if (NUM_LDEV == 0 || NUM_LDEV > SEL_SPAN) begin : g_bad_count
      $error("sio_ldev_bank: NUM_LDEV out of range");
   end
   if (MON_LDEV >= NUM_LDEV) begin : g_bad_mon
      $error("sio_ldev_bank: MON_LDEV must be a valid device");
   end

   logic [15:0] base_arr [NUM_LDEV];

   for (genvar g = 0; g < NUM_LDEV; g++) begin : g_dev
      localparam byte_t       DEV_ID  = byte_t'(g);
      localparam logic [15:0] RST_VAL = (g == MON_LDEV) ? MON_BASE_RST : DEV_BASE_RST;
      logic [15:0] base_q;
      logic        hit;

      assign hit = (sel == DEV_ID);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q <= RST_VAL;
         end else if (hit) begin
            if (wr_hi) base_q[15:8] <= wdata;
            if (wr_lo) base_q[7:0]  <= wdata;
         end
      end

      assign base_arr[g] = base_q;
   end

   always_comb begin
      rd_hi = '0;
      rd_lo = '0;
      for (int i = 0; i < NUM_LDEV; i++) begin
         if (sel == byte_t'(i)) begin
            rd_hi = base_arr[i][15:8];
            rd_lo = base_arr[i][7:0];
         end
      end
   end

   assign mon_base = base_arr[MON_LDEV];

   // R9: the monitor base moves only after a base byte write
   a_r9_mon_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mon_base) |-> $past(wr_hi || wr_lo));
endmodule

// File: rtl/sio_cfg_rdmux.sv
module sio_cfg_rdmux
   import sio_cfg_pkg::*;
#(
   parameter logic [15:0] CHIP_ID = 16'h0541,
   parameter logic [15:0] MFG_ID  = 16'h1934
) (
   input  byte_t index,
   input  byte_t ldsel,
   input  byte_t base_hi,
   input  byte_t base_lo,
   output byte_t cfg_byte
);
   always_comb begin
      case (index)
         IX_LDSEL:   cfg_byte = ldsel;
         IX_CHIP_HI: cfg_byte = CHIP_ID[15:8];
         IX_CHIP_LO: cfg_byte = CHIP_ID[7:0];
         IX_MFG_HI:  cfg_byte = MFG_ID[15:8];
         IX_MFG_LO:  cfg_byte = MFG_ID[7:0];
         IX_BASE_HI: cfg_byte = base_hi;
         IX_BASE_LO: cfg_byte = base_lo;
         default:    cfg_byte = '0;
      endcase
   end
endmodule

// File: rtl/sio_cfg_window.sv
module sio_cfg_window
   import sio_cfg_pkg::*;
#(
   parameter int unsigned NUM_LDEV     = 8,
   parameter int unsigned MON_LDEV     = 4,
   parameter logic [15:0] CHIP_ID      = 16'h0541,
   parameter logic [15:0] MFG_ID       = 16'h1934,
   parameter logic [15:0] MON_BASE_RST = 16'h0290,
   parameter logic [7:0]  KEY_BYTE     = 8'h87,
   parameter logic [7:0]  LOCK_BYTE    = 8'hAA,
   parameter logic [7:0]  LOCKED_FILL  = 8'hFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        addr,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [7:0]  wdata,
   output logic [7:0]  rdata,
   output logic [15:0] mon_base
);
   logic  open;
   logic  idx_wr;
   logic  dat_wr;
   byte_t index_q;
   byte_t ldsel_q;
   byte_t rdata_q;
   byte_t base_hi;
   byte_t base_lo;
   byte_t cfg_byte;

   assign idx_wr = wr_en && !addr;
   assign dat_wr = wr_en && addr && open;

   sio_key_gate #(
      .KEY_BYTE (KEY_BYTE),
      .LOCK_BYTE(LOCK_BYTE)
   ) u_key (
      .clk   (clk),
      .rst_n (rst_n),
      .idx_wr(idx_wr),
      .wdata (wdata),
      .open  (open)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                                       index_q <= '0;
      else if (idx_wr && open && wdata != LOCK_BYTE)    index_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                  ldsel_q <= '0;
      else if (dat_wr && index_q == IX_LDSEL)      ldsel_q <= wdata;
   end

   sio_ldev_bank #(
      .NUM_LDEV    (NUM_LDEV),
      .MON_LDEV    (MON_LDEV),
      .MON_BASE_RST(MON_BASE_RST),
      .DEV_BASE_RST(16'h0000)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (ldsel_q),
      .wr_hi   (dat_wr && index_q == IX_BASE_HI),
      .wr_lo   (dat_wr && index_q == IX_BASE_LO),
      .wdata   (wdata),
      .rd_hi   (base_hi),
      .rd_lo   (base_lo),
      .mon_base(mon_base)
   );

   sio_cfg_rdmux #(
      .CHIP_ID(CHIP_ID),
      .MFG_ID (MFG_ID)
   ) u_rdmux (
      .index   (index_q),
      .ldsel   (ldsel_q),
      .base_hi (base_hi),
      .base_lo (base_lo),
      .cfg_byte(cfg_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        rdata_q <= '0;
      else if (rd_en) begin
         if (!open)      rdata_q <= LOCKED_FILL;
         else if (addr)  rdata_q <= cfg_byte;
         else            rdata_q <= index_q;
      end
   end

   assign rdata = rdata_q;

   // R4: a read while closed returns the fill byte
   a_r4_locked_read_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !open) |=> (rdata == LOCKED_FILL));
   // R1: read data holds when no read strobe is present
   a_r1_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
   // R7: the device select only moves on an open data-port write
   a_r7_ldsel_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !dat_wr |=> $stable(ldsel_q));
   // R4: the index is untouched while closed
   a_r4_index_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !open |=> $stable(index_q));
endmodule

// File: tb/sio_cfg_window_test.sv
`timescale 1ns/1ps
module sio_cfg_window_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  wdata = 8'h00;
   logic [7:0]  rdata;
   logic [15:0] mon_base;

   int errors = 0;
   int checks = 0;
   logic [7:0]  m_ldsel;
   logic [15:0] m_base [8];

   always #10 clk = ~clk;

   sio_cfg_window uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .mon_base(mon_base)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic a);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   function automatic logic [7:0] model(input logic [7:0] idx);
      logic [15:0] b;
      b = (m_ldsel < 8) ? m_base[m_ldsel[2:0]] : 16'h0000;
      case (idx)
         8'h07: return m_ldsel;
         8'h20: return 8'h05;
         8'h21: return 8'h41;
         8'h23: return 8'h19;
         8'h24: return 8'h34;
         8'h60: return b[15:8];
         8'h61: return b[7:0];
         default: return 8'h00;
      endcase
   endfunction

   task automatic unlock();
      wr(1'b0, 8'h87);
      wr(1'b0, 8'h87);
   endtask

   task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
      wr(1'b0, idx);
      wr(1'b1, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      m_ldsel = 8'h00;
      for (int i = 0; i < 8; i++) m_base[i] = (i == 4) ? 16'h0290 : 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 reset state
      chk("R5 rdata reset", {8'h00, rdata}, 16'h0000);
      chk("R5 mon_base reset", mon_base, 16'h0290);
      rd(1'b1);
      chk("R4 closed data read", {8'h00, rdata}, 16'h00FF);
      rd(1'b0);
      chk("R4 closed index read", {8'h00, rdata}, 16'h00FF);

      // R2 every stray byte between keys keeps the space shut
      for (int x = 0; x < 256; x++) begin
         if (x != 8'h87) begin
            wr(1'b0, 8'h87);
            wr(1'b0, 8'(x));
            wr(1'b0, 8'h87);
            rd(1'b1);
            chk("R2 stray byte blocks open", {8'h00, rdata}, 16'h00FF);
            wr(1'b0, 8'h00);
         end
      end

      unlock();
      wr(1'b0, 8'h07);
      rd(1'b1);
      chk("R5 ldsel reset", {8'h00, rdata}, 16'h0000);
      rd(1'b0);
      chk("R11 index readback", {8'h00, rdata}, 16'h0007);

      // R6 IDs, then writes ignored
      for (int k = 0; k < 4; k++) begin
         logic [7:0] ix;
         ix = (k < 2) ? 8'(8'h20 + k) : 8'(8'h21 + k);
         wr(1'b0, ix);
         rd(1'b1);
         chk("R6 id read", {8'h00, rdata}, {8'h00, model(ix)});
         wr(1'b1, 8'h55);
         rd(1'b1);
         chk("R6 id write ignored", {8'h00, rdata}, {8'h00, model(ix)});
      end

      // R8 bank load, R9 monitor follows device 4
      for (int d = 0; d < 8; d++) begin
         logic [15:0] pat;
         pat = {8'(8'h11 * (d + 1)), 8'(8'hC3 ^ d)};
         set_reg(8'h07, 8'(d));
         m_ldsel = 8'(d);
         set_reg(8'h60, pat[15:8]);
         set_reg(8'h61, pat[7:0]);
         m_base[d] = pat;
         chk("R9 mon_base tracks device 4", mon_base, m_base[4]);
      end
      for (int d = 0; d < 8; d++) begin
         set_reg(8'h07, 8'(d));
         m_ldsel = 8'(d);
         wr(1'b0, 8'h60);
         rd(1'b1);
         chk("R8 base high per device", {8'h00, rdata}, {8'h00, m_base[d][15:8]});
         wr(1'b0, 8'h61);
         rd(1'b1);
         chk("R8 base low per device", {8'h00, rdata}, {8'h00, m_base[d][7:0]});
      end
      // R8 out-of-range selects
      for (int s = 8; s < 256; s += 41) begin
         set_reg(8'h07, 8'(s));
         m_ldsel = 8'(s);
         set_reg(8'h60, 8'h99);
         rd(1'b1);
         chk("R8 unbacked select reads zero", {8'h00, rdata}, 16'h0000);
      end
      chk("R9 mon_base unchanged by unbacked write", mon_base, m_base[4]);

      // R10/R7/R6/R8 exhaustive index sweep with device 3 selected
      set_reg(8'h07, 8'h03);
      m_ldsel = 8'h03;
      for (int i = 0; i < 256; i++) begin
         if (i != 8'hAA) begin
            wr(1'b0, 8'(i));
            rd(1'b1);
            chk("R10 index sweep", {8'h00, rdata}, {8'h00, model(8'(i))});
         end
      end

      // R3 lock, R4 writes ignored while closed
      set_reg(8'h07, 8'h04);
      m_ldsel = 8'h04;
      wr(1'b0, 8'h60);
      wr(1'b0, 8'hAA);
      rd(1'b1);
      chk("R3 lock closes", {8'h00, rdata}, 16'h00FF);
      wr(1'b1, 8'h77);
      chk("R4 closed write leaves mon_base", mon_base, m_base[4]);
      unlock();
      rd(1'b0);
      chk("R4 index kept across lock", {8'h00, rdata}, 16'h0060);
      rd(1'b1);
      chk("R4 closed write ignored", {8'h00, rdata}, {8'h00, m_base[4][15:8]});

      // R9 update right after the write edge
      wr(1'b0, 8'h61);
      wr(1'b1, 8'h5A);
      m_base[4][7:0] = 8'h5A;
      chk("R9 mon_base after write edge", mon_base, m_base[4]);

      // R1 read data holds without strobe
      rd(1'b1);
      repeat (3) @(negedge clk);
      chk("R1 rdata held", {8'h00, rdata}, 16'h005A);
      wr(1'b0, 8'h07);
      chk("R1 rdata held across index write", {8'h00, rdata}, 16'h005A);
      rd(1'b1);
      chk("R1 rdata after read", {8'h00, rdata}, 16'h0004);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule